// File: doc/BRIEF.md
# Dual-Source Output Queue Arbiter

This block holds bytes for a host that reads them one at a time. It has two independent byte queues. One is for a primary input device and the other is for an auxiliary pointing device. Producers push bytes that are already formed into either queue. The host pulls them through one read strobe, and only the primary queue is consulted while it holds data. The auxiliary queue is read only when the primary queue is empty.

The block also gives a status byte. Status bit 0 means data is waiting. Status bit 5 means the waiting byte belongs to the auxiliary queue. Two level interrupt lines follow the same priority, so at most one of them is high at any time. A read that finds both queues empty repeats the last byte taken from the primary queue and leaves everything else alone. This copes with software that polls too often.

Top module: `dual_queue_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `status` is 0x1C, both interrupt lines are low and `rd_data` is 0x00.
- R2: Each queue holds up to DEPTH (default 128) bytes and returns them in the order they were pushed.
- R3: A push to a queue that already holds DEPTH bytes is dropped. The bytes stored before it are unchanged, and the count never exceeds DEPTH.
- R4: While the primary queue holds data, status bit 0 is 1, status bit 5 is 0, `pri_irq` is 1 and `aux_irq` is 0.
- R5: While the primary queue is empty and the auxiliary queue holds data, status bits 0 and 5 are both 1, `aux_irq` is 1 and `pri_irq` is 0.
- R6: While both queues are empty, status bits 0 and 5 are 0 and both interrupt lines are low. Status bits 2, 3 and 4 are always 1, and bits 1, 6 and 7 are always 0.
- R7: A read takes the oldest primary byte whenever the primary queue holds data. Otherwise it takes the oldest auxiliary byte. The popped byte appears on `rd_data` one clock after the read strobe and stays there until the next read.
- R8: A read with both queues empty presents the most recently popped primary byte on `rd_data`, or 0x00 if none has been popped. It changes no queue content or count.
- R9: A push and a pop that hit the same queue in the same cycle both take effect, so that queue's count does not change.
- R10: Status bits 0 and 5 and both interrupt lines show the queue contents in the cycle right after the clock edge that applied a push or pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_push | input | 1 | Push strobe for the primary queue |
| pri_data | input | DATA_W | Byte pushed to the primary queue |
| aux_push | input | 1 | Push strobe for the auxiliary queue |
| aux_data | input | DATA_W | Byte pushed to the auxiliary queue |
| rd | input | 1 | Host read strobe, one pop per cycle asserted |
| rd_data | output | DATA_W | Byte returned by the most recent read |
| status | output | 8 | Status byte (bit 0 data pending, bit 5 auxiliary source) |
| pri_irq | output | 1 | Primary interrupt level |
| aux_irq | output | 1 | Auxiliary interrupt level |

## Verification
The properties treat every strobe as a separate single-cycle event that may coincide with any other strobe. The count-stability properties only apply in cycles where the other queue's push is absent. Pushes into a full queue are legal, and the bench issues them on purpose. The bench drives the read strobe together with pushes, both on the same queue and on the other queue. The sweep changes its push and read densities between phases, so both queues pass through empty, partly filled and full.

// File: rtl/dqa_pkg.sv
`timescale 1ns/1ps
package dqa_pkg;
  localparam int          ST_PENDING = 0;
  localparam int          ST_FROMAUX = 5;
  localparam logic [7:0]  ST_BASE    = 8'h1C;
endpackage

// File: rtl/dqa_byte_queue.sv
`timescale 1ns/1ps
module dqa_byte_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              take;

  assign take = push && (count != CNT_W'(DEPTH));

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (take) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (take) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({take, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dqa_read_arb.sv
`timescale 1ns/1ps
module dqa_read_arb
  import dqa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [CNT_W-1:0]  pri_cnt,
  input  logic [CNT_W-1:0]  aux_cnt,
  input  logic [DATA_W-1:0] pri_dout,
  input  logic [DATA_W-1:0] aux_dout,
  output logic              pri_pop,
  output logic              aux_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status,
  output logic              pri_irq,
  output logic              aux_irq
);
  logic pri_has, aux_has, src_aux;

  assign pri_has = (pri_cnt != '0);
  assign aux_has = (aux_cnt != '0);
  assign pri_pop = rd && pri_has;
  assign aux_pop = rd && !pri_has && aux_has;

  // remembers which queue fed the last read; an empty read selects primary
  always_ff @(posedge clk) begin
    if (rst)     src_aux <= 1'b0;
    else if (rd) src_aux <= aux_pop;
  end

  assign rd_data = src_aux ? aux_dout : pri_dout;

  always_comb begin
    status             = ST_BASE;
    status[ST_PENDING] = pri_has || aux_has;
    status[ST_FROMAUX] = !pri_has && aux_has;
  end

  assign pri_irq = pri_has;
  assign aux_irq = !pri_has && aux_has;
endmodule

// File: rtl/dual_queue_arbiter.sv
`timescale 1ns/1ps
module dual_queue_arbiter #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pri_push,
  input  logic [DATA_W-1:0] pri_data,
  input  logic              aux_push,
  input  logic [DATA_W-1:0] aux_data,
  input  logic              rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status,
  output logic              pri_irq,
  output logic              aux_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NQ    = 2; // index 0 primary, 1 auxiliary

  logic [NQ-1:0]             q_push, q_pop;
  logic [NQ-1:0][DATA_W-1:0] q_din, q_dout;
  logic [NQ-1:0][CNT_W-1:0]  q_cnt;

  assign q_push = {aux_push, pri_push};
  assign q_din  = {aux_data, pri_data};

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    dqa_byte_queue #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
    ) u_q (
      .clk  (clk),
      .rst  (rst),
      .push (q_push[g]),
      .din  (q_din[g]),
      .pop  (q_pop[g]),
      .dout (q_dout[g]),
      .count(q_cnt[g])
    );
  end

  dqa_read_arb #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .rd      (rd),
    .pri_cnt (q_cnt[0]),
    .aux_cnt (q_cnt[1]),
    .pri_dout(q_dout[0]),
    .aux_dout(q_dout[1]),
    .pri_pop (q_pop[0]),
    .aux_pop (q_pop[1]),
    .rd_data (rd_data),
    .status  (status),
    .pri_irq (pri_irq),
    .aux_irq (aux_irq)
  );
endmodule

// File: rtl/dqa_checker.sv
`timescale 1ns/1ps
module dqa_checker #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rd,
  input logic             pri_push,
  input logic             aux_push,
  input logic [CNT_W-1:0] pri_cnt,
  input logic [CNT_W-1:0] aux_cnt,
  input logic [7:0]       status,
  input logic             pri_irq,
  input logic             aux_irq
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (pri_cnt <= CNT_W'(DEPTH)) && (aux_cnt <= CNT_W'(DEPTH)));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (pri_cnt == CNT_W'(DEPTH)) && pri_push && !rd |=> pri_cnt == CNT_W'(DEPTH));

  a_r4_pri_owns: assert property (@(posedge clk) disable iff (rst)
    pri_irq |-> status[0] && !status[5] && !aux_irq);

  a_r5_aux_alone: assert property (@(posedge clk) disable iff (rst)
    aux_irq |-> status[0] && status[5] && !pri_irq);

  a_r6_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (status[4:2] == 3'b111) && (status[7:6] == 2'b00) && !status[1]);

  a_r7_pri_first: assert property (@(posedge clk) disable iff (rst)
    rd && (pri_cnt != '0) && !aux_push |=> $stable(aux_cnt));

  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    rd && !status[0] && !pri_push && !aux_push |=> !status[0] && !pri_irq && !aux_irq);

  a_r9_push_pop_same: assert property (@(posedge clk) disable iff (rst)
    rd && (pri_cnt != '0) && (pri_cnt != CNT_W'(DEPTH)) && pri_push |=> $stable(pri_cnt));
endmodule

bind dual_queue_arbiter dqa_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dqa_chk (
  .clk     (clk),
  .rst     (rst),
  .rd      (rd),
  .pri_push(pri_push),
  .aux_push(aux_push),
  .pri_cnt (q_cnt[0]),
  .aux_cnt (q_cnt[1]),
  .status  (status),
  .pri_irq (pri_irq),
  .aux_irq (aux_irq)
);

// File: tb/tb_dual_queue_arbiter.sv
`timescale 1ns/1ps
module tb_dual_queue_arbiter;
  localparam int DW    = 8;
  localparam int DEPTH = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          pri_push, aux_push, rd;
  logic [DW-1:0] pri_data, aux_data;
  logic [DW-1:0] rd_data;
  logic [7:0]    status;
  logic          pri_irq, aux_irq;

  always #2.5 clk = ~clk;

  dual_queue_arbiter #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .pri_push(pri_push), .pri_data(pri_data),
    .aux_push(aux_push), .aux_data(aux_data),
    .rd(rd), .rd_data(rd_data), .status(status),
    .pri_irq(pri_irq), .aux_irq(aux_irq)
  );

  int            n_cmp = 0;
  int            n_bad = 0;
  logic [7:0]    mp[$];
  logic [7:0]    ma[$];
  logic [7:0]    last_pri = 8'h00;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s = 8'h1C;
    if (mp.size() != 0 || ma.size() != 0) s[0] = 1'b1;
    if (mp.size() == 0 && ma.size() != 0) s[5] = 1'b1;
    return s;
  endfunction

  task automatic cyc(input logic pp, input logic [7:0] pd, input logic ap,
                     input logic [7:0] ad, input logic r, input string tag);
    int np;
    int na;
    logic [7:0] ex;
    np = mp.size();
    na = ma.size();
    ex = 8'h00;
    pri_push = pp; pri_data = pd; aux_push = ap; aux_data = ad; rd = r;
    @(posedge clk); #2;
    pri_push = 1'b0; aux_push = 1'b0; rd = 1'b0;
    if (r) begin
      if (np > 0) begin
        ex = mp.pop_front();
        last_pri = ex;
      end else if (na > 0) begin
        ex = ma.pop_front();
      end else begin
        ex = last_pri;
      end
    end
    if (pp && np < DEPTH) mp.push_back(pd);
    if (ap && na < DEPTH) ma.push_back(ad);
    if (r) chk({tag, " rd_data R7"}, rd_data, ex);
    chk({tag, " status R6 R10"}, status, exp_status());
    chk({tag, " irq R4 R5"}, {6'd0, aux_irq, pri_irq},
        {6'd0, (mp.size() == 0 && ma.size() != 0), (mp.size() != 0)});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #400us;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] s;
    rst = 1'b1;
    pri_push = 1'b0; aux_push = 1'b0; rd = 1'b0;
    pri_data = '0; aux_data = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 status in reset", status, 8'h1C);
    chk("R1 irq in reset", {6'd0, aux_irq, pri_irq}, 8'h00);
    rst = 1'b0;
    @(posedge clk); #2;
    chk("R1 status after reset", status, 8'h1C);
    chk("R1 rd_data after reset", rd_data, 8'h00);

    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R8 empty read before data");

    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b1, 8'h40 + 8'(i), 1'b0, "R5 aux fill");
    for (int i = 0; i < 2; i++) cyc(1'b1, 8'h10 + 8'(i), 1'b0, 8'h00, 1'b0, "R4 pri fill");
    for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R7 priority read");
    cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R8 empty read after aux");

    for (int i = 0; i < DEPTH + 2; i++) cyc(1'b1, 8'(i) ^ 8'h5A, 1'b0, 8'h00, 1'b0, "R3 pri overfill");
    for (int i = 0; i < DEPTH + 1; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R2 pri drain");
    for (int i = 0; i < DEPTH + 2; i++) cyc(1'b0, 8'h00, 1'b1, 8'(3 * i + 1), 1'b0, "R3 aux overfill");
    for (int i = 0; i < DEPTH + 1; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R2 aux drain R8");

    cyc(1'b1, 8'hA0, 1'b0, 8'h00, 1'b0, "R9 setup");
    cyc(1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, "R9 setup");
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'hB0 + 8'(i), 1'b1, 8'hC0 + 8'(i), 1'b1, "R9 push pop same");
    for (int i = 0; i < 8; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, "R9 drain");

    s = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      logic pp, ap, r;
      s  = s * 32'd1103515245 + 32'd12345;
      case ((k / 500) % 3)
        0:       begin pp = s[16] | s[17]; ap = s[18] | s[19]; r = s[20] & s[21]; end
        1:       begin pp = s[16] & s[17]; ap = s[18] & s[19]; r = s[20] | s[21]; end
        default: begin pp = s[16];         ap = s[18];         r = s[20];         end
      endcase
      cyc(pp, s[31:24], ap, s[15:8], r, "R2 R7 R9 sweep");
    end

    summary();
    $finish;
  end
endmodule